// File: doc/BRIEF.md
# Stack Call/Return Sequencer

This block carries out the stack-class instructions of a small 16-bit processor. It handles five of them: push a register, pop into a register, call with an absolute target, call with a PC-relative target, and return. Any one of the general-purpose registers can act as the stack pointer. The decode logic picks that register through an index input. By convention software uses register 7.

When `start` is accepted, the block captures the following from its inputs:

- the opcode
- both register indices
- the stack-pointer value and the source-register value, both read from the register file
- the PC of the following instruction
- the immediate word

It then steps through a short fixed sequence. In that sequence it drives one word-wide memory access, tells the register file to step the pointer register by two, and writes the destination register or updates the PC. A one-cycle `done` marks the last step. A bus fault during the memory access cuts the sequence short, and the block reports it with a one-cycle `err`.

Memory is synchronous. Read data is taken in the cycle after the read strobe. `mem_err` is sampled in the strobe cycle itself.

Top module: `stack_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `err` and every strobe and command output are 0, and all data, address and index outputs are 0.
- R2: Push (op 0) is a sequence of two steps. The first step is a word write of the source value to the captured pointer address. The second step is a decrement of the pointer register, with `done` high.
- R3: Pop (op 1) is a sequence of three steps:
  - an increment of the pointer register;
  - a word read at pointer+2;
  - a write of the read data into the destination register, with `done` high.
- R4: Call-absolute (op 2) is a sequence of three steps:
  - a decrement of the pointer register;
  - a word write of the captured next-instruction PC to pointer-2;
  - a `pc_load` of the immediate word, with `done` high.
- R5: Call-relative (op 3) is the same sequence as R4, except that the last step raises `pc_add` with the immediate word as `pc_value`.
- R6: Return (op 4) is a sequence of three steps:
  - a word read at the pointer address;
  - a `pc_load` of the read data;
  - an increment of the pointer register, with `done` high.
- R7: All operands are captured in the accept cycle. Later changes to the opcode, indices, values and immediate have no effect on the running sequence, and the pointer commands use the captured pointer index (any of 0..7).
- R8: `mem_word` is high whenever `mem_rd` or `mem_wr` is high. Read and write are never high together, nor are increment and decrement. Any data, address or index output not in use in a cycle is 0.
- R9: `done` lasts exactly one cycle per completed sequence. `start` is ignored while `busy` is high. While idle, no strobe or command output is raised.
- R10: When `mem_err` is high in the access cycle, the next cycle raises `err` alone with `busy`, and the block then returns to idle. No `done` is raised, and no further pointer, register or PC command is issued.
- R11: Opcodes 5 to 7 are ignored: `start` with such an opcode leaves the block idle with all outputs 0.
- R12: Stack addresses wrap modulo 2^16, so pointer 0x0000 gives a call address of 0xFFFE and pointer 0xFFFE gives a pop address of 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sequence (accepted only while idle) |
| op | input | 3 | Stack opcode: 0 push, 1 pop, 2 call-absolute, 3 call-relative, 4 return |
| sp_sel | input | 3 | Index of the register used as stack pointer |
| reg_sel | input | 3 | Index of the destination register for pop |
| sp_val | input | 16 | Current value of the pointer register |
| src_val | input | 16 | Value of the register to push |
| pc_next | input | 16 | Address of the instruction after the current one |
| imm_word | input | 16 | Immediate word for calls |
| mem_rdata | input | 16 | Read data, valid in the cycle after `mem_rd` |
| mem_err | input | 1 | Bus fault for the current access |
| mem_addr | output | 16 | Byte address of the access |
| mem_wdata | output | 16 | Write data |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_word | output | 1 | Word-wide cycle marker |
| rf_inc | output | 1 | Increment pointer register by two |
| rf_dec | output | 1 | Decrement pointer register by two |
| rf_step_sel | output | 3 | Register index for increment/decrement |
| rf_wr | output | 1 | Register write strobe |
| rf_wr_sel | output | 3 | Register index to write |
| rf_wr_data | output | 16 | Register write data |
| pc_load | output | 1 | Replace PC with `pc_value` |
| pc_add | output | 1 | Add `pc_value` to PC |
| pc_value | output | 16 | New PC or offset |
| busy | output | 1 | A sequence or fault step is in progress |
| done | output | 1 | Last step of a completed sequence |
| err | output | 1 | Sequence aborted by a bus fault |

## Verification
The bound assertions check every cycle for the invariants:

- the word marker is raised on every access;
- read and write strobes are exclusive, and so are increment and decrement;
- `done` is a single-cycle pulse;
- the block is silent while idle;
- an `err` cycle issues no pointer, register or PC command and follows a faulting access.

Only the bench's scenarios can show the rest:

- the order of the steps for each opcode;
- the addresses and data values;
- that operands are captured at accept time;
- address wrap at the ends of memory;
- that opcodes 5 to 7 are ignored.

The bench does this by comparing every output against a step list built from R2 to R6.

// File: rtl/sseq_pkg.sv
// Package: shared opcode and state types for the stack sequencer.
// Assumes a 3-bit opcode field supplied by the instruction decoder.
package sseq_pkg;

    typedef enum logic [2:0] {
        SK_PUSH     = 3'd0,
        SK_PULL     = 3'd1,
        SK_CALL_ABS = 3'd2,
        SK_CALL_REL = 3'd3,
        SK_RETURN   = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRE   = 3'd1,
        ST_ACC   = 3'd2,
        ST_CAP   = 3'd3,
        ST_POST  = 3'd4,
        ST_PCUP  = 3'd5,
        ST_FAULT = 3'd6
    } st_e;

    function automatic logic op_ok(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

    function automatic logic op_is_call(input op_e code);
        return (code == SK_CALL_ABS) || (code == SK_CALL_REL);
    endfunction

endpackage

// File: rtl/sseq_ctrl.sv
// Module: sseq_ctrl
// Step sequencer of the stack block. Accepts a valid opcode while idle,
// then walks the fixed step list for that opcode. A bus fault seen in
// the access step diverts to a single fault step.
// Assumes mem_err is meaningful only in the access step.
module sseq_ctrl
    import sseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [2:0] op_in,
    input  logic       mem_err,
    output st_e        st,
    output op_e        op_q,
    output logic       take
);

    st_e nxt;

    // Purpose: accept a request only when idle and the opcode is defined.
    assign take = (st == ST_IDLE) && start && op_ok(op_in);

    // Purpose: choose the next step from the current step and opcode.
    always_comb begin
        nxt = st;
        case (st)
            ST_IDLE: begin
                if (take) begin
                    if ((op_e'(op_in) == SK_PULL) || op_is_call(op_e'(op_in)))
                        nxt = ST_PRE;
                    else
                        nxt = ST_ACC;
                end
            end
            ST_PRE:  nxt = ST_ACC;
            ST_ACC: begin
                if (mem_err) begin
                    nxt = ST_FAULT;
                end else begin
                    case (op_q)
                        SK_PUSH:             nxt = ST_POST;
                        SK_PULL, SK_RETURN:  nxt = ST_CAP;
                        default:             nxt = ST_PCUP;
                    endcase
                end
            end
            ST_CAP:   nxt = (op_q == SK_RETURN) ? ST_POST : ST_IDLE;
            ST_POST:  nxt = ST_IDLE;
            ST_PCUP:  nxt = ST_IDLE;
            ST_FAULT: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Purpose: step register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Purpose: hold the accepted opcode for the whole sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)    op_q <= SK_PUSH;
        else if (take) op_q <= op_e'(op_in);
    end

endmodule

// File: rtl/sseq_dpath.sv
// Module: sseq_dpath
// Operand capture for the stack block. On accept it stores the register
// indices, the immediate, and precomputes the stack address and the
// word to be written. Pop addresses pointer+STEP, calls address
// pointer-STEP, push and return address the pointer itself.
// Assumes the register file supplies pointer and source values in the
// accept cycle.
module sseq_dpath
    import sseq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int RIDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [2:0]        op_in,
    input  logic [RIDX_W-1:0] sp_sel,
    input  logic [RIDX_W-1:0] reg_sel,
    input  logic [DATA_W-1:0] sp_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic [DATA_W-1:0] pc_next,
    input  logic [DATA_W-1:0] imm_word,
    output logic [RIDX_W-1:0] sp_sel_q,
    output logic [RIDX_W-1:0] reg_sel_q,
    output logic [DATA_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] imm_q
);

    localparam logic [DATA_W-1:0] STEP_V = DATA_W'(DATA_W / 8);

    logic [DATA_W-1:0] addr_d;
    logic [DATA_W-1:0] wdata_d;
    op_e               op_v;

    assign op_v = op_e'(op_in);

    // Purpose: form the stack address and write word for the new opcode.
    always_comb begin
        addr_d  = sp_val;
        wdata_d = '0;
        case (op_v)
            SK_PUSH: wdata_d = src_val;
            SK_PULL: addr_d  = sp_val + STEP_V;
            SK_CALL_ABS, SK_CALL_REL: begin
                addr_d  = sp_val - STEP_V;
                wdata_d = pc_next;
            end
            default: ;
        endcase
    end

    // Purpose: capture operands in the accept cycle only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_sel_q  <= '0;
            reg_sel_q <= '0;
            addr_q    <= '0;
            wdata_q   <= '0;
            imm_q     <= '0;
        end else if (take) begin
            sp_sel_q  <= sp_sel;
            reg_sel_q <= reg_sel;
            addr_q    <= addr_d;
            wdata_q   <= wdata_d;
            imm_q     <= imm_word;
        end
    end

endmodule

// File: rtl/sseq_outmux.sv
// Module: sseq_outmux
// Output decode of the stack block: turns the current step and opcode
// into memory, register-file and PC commands. Every output not in use
// in a step is driven to zero.
// Assumes read data arrives in the step after the read strobe.
module sseq_outmux
    import sseq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int RIDX_W = 3
) (
    input  st_e               st,
    input  op_e               op_q,
    input  logic [RIDX_W-1:0] sp_sel_q,
    input  logic [RIDX_W-1:0] reg_sel_q,
    input  logic [DATA_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic [DATA_W-1:0] imm_q,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_word,
    output logic              rf_inc,
    output logic              rf_dec,
    output logic [RIDX_W-1:0] rf_step_sel,
    output logic              rf_wr,
    output logic [RIDX_W-1:0] rf_wr_sel,
    output logic [DATA_W-1:0] rf_wr_data,
    output logic              pc_load,
    output logic              pc_add,
    output logic [DATA_W-1:0] pc_value,
    output logic              busy,
    output logic              done,
    output logic              err
);

    // Purpose: drive the commands that belong to the current step.
    always_comb begin
        mem_addr    = '0;
        mem_wdata   = '0;
        mem_rd      = 1'b0;
        mem_wr      = 1'b0;
        mem_word    = 1'b0;
        rf_inc      = 1'b0;
        rf_dec      = 1'b0;
        rf_step_sel = '0;
        rf_wr       = 1'b0;
        rf_wr_sel   = '0;
        rf_wr_data  = '0;
        pc_load     = 1'b0;
        pc_add      = 1'b0;
        pc_value    = '0;
        done        = 1'b0;
        err         = 1'b0;
        busy        = (st != ST_IDLE);
        case (st)
            ST_PRE: begin
                rf_step_sel = sp_sel_q;
                if (op_q == SK_PULL) rf_inc = 1'b1;
                else                 rf_dec = 1'b1;
            end
            ST_ACC: begin
                mem_word = 1'b1;
                mem_addr = addr_q;
                if ((op_q == SK_PULL) || (op_q == SK_RETURN)) begin
                    mem_rd = 1'b1;
                end else begin
                    mem_wr    = 1'b1;
                    mem_wdata = wdata_q;
                end
            end
            ST_CAP: begin
                if (op_q == SK_PULL) begin
                    rf_wr      = 1'b1;
                    rf_wr_sel  = reg_sel_q;
                    rf_wr_data = mem_rdata;
                    done       = 1'b1;
                end else begin
                    pc_load  = 1'b1;
                    pc_value = mem_rdata;
                end
            end
            ST_POST: begin
                rf_step_sel = sp_sel_q;
                done        = 1'b1;
                if (op_q == SK_RETURN) rf_inc = 1'b1;
                else                   rf_dec = 1'b1;
            end
            ST_PCUP: begin
                pc_value = imm_q;
                done     = 1'b1;
                if (op_q == SK_CALL_REL) pc_add  = 1'b1;
                else                     pc_load = 1'b1;
            end
            ST_FAULT: err = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/stack_seq.sv
// Module: stack_seq (top)
// Multi-cycle sequencer for push, pop, call (absolute or relative) and
// return, using any general register as stack pointer. The pointer
// always moves by one word (two bytes) and all accesses are word wide.
// Assumes a synchronous memory: read data one cycle after the strobe,
// bus fault flagged in the strobe cycle.
module stack_seq
    import sseq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int RIDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [RIDX_W-1:0] sp_sel,
    input  logic [RIDX_W-1:0] reg_sel,
    input  logic [DATA_W-1:0] sp_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic [DATA_W-1:0] pc_next,
    input  logic [DATA_W-1:0] imm_word,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_err,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_word,
    output logic              rf_inc,
    output logic              rf_dec,
    output logic [RIDX_W-1:0] rf_step_sel,
    output logic              rf_wr,
    output logic [RIDX_W-1:0] rf_wr_sel,
    output logic [DATA_W-1:0] rf_wr_data,
    output logic              pc_load,
    output logic              pc_add,
    output logic [DATA_W-1:0] pc_value,
    output logic              busy,
    output logic              done,
    output logic              err
);

    st_e               st;
    op_e               op_q;
    logic              take;
    logic [RIDX_W-1:0] sp_sel_q;
    logic [RIDX_W-1:0] reg_sel_q;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] imm_q;

    sseq_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op_in   (op),
        .mem_err (mem_err),
        .st      (st),
        .op_q    (op_q),
        .take    (take)
    );

    sseq_dpath #(.DATA_W(DATA_W), .RIDX_W(RIDX_W)) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .op_in     (op),
        .sp_sel    (sp_sel),
        .reg_sel   (reg_sel),
        .sp_val    (sp_val),
        .src_val   (src_val),
        .pc_next   (pc_next),
        .imm_word  (imm_word),
        .sp_sel_q  (sp_sel_q),
        .reg_sel_q (reg_sel_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .imm_q     (imm_q)
    );

    sseq_outmux #(.DATA_W(DATA_W), .RIDX_W(RIDX_W)) u_outmux (
        .st          (st),
        .op_q        (op_q),
        .sp_sel_q    (sp_sel_q),
        .reg_sel_q   (reg_sel_q),
        .addr_q      (addr_q),
        .wdata_q     (wdata_q),
        .imm_q       (imm_q),
        .mem_rdata   (mem_rdata),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rd      (mem_rd),
        .mem_wr      (mem_wr),
        .mem_word    (mem_word),
        .rf_inc      (rf_inc),
        .rf_dec      (rf_dec),
        .rf_step_sel (rf_step_sel),
        .rf_wr       (rf_wr),
        .rf_wr_sel   (rf_wr_sel),
        .rf_wr_data  (rf_wr_data),
        .pc_load     (pc_load),
        .pc_add      (pc_add),
        .pc_value    (pc_value),
        .busy        (busy),
        .done        (done),
        .err         (err)
    );

endmodule

// File: rtl/stack_seq_chk.sv
// Module: stack_seq_chk
// Cycle-by-cycle protocol checks on the stack sequencer ports, bound
// into every instance of stack_seq.
module stack_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic mem_err,
    input logic mem_rd,
    input logic mem_wr,
    input logic mem_word,
    input logic rf_inc,
    input logic rf_dec,
    input logic rf_wr,
    input logic pc_load,
    input logic pc_add,
    input logic busy,
    input logic done,
    input logic err
);

    AST_WORD_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> mem_word);                                  // R8
    AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));                                              // R8
    AST_STEP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_inc && rf_dec));                                              // R8
    AST_PC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pc_load, pc_add}));                                      // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                   // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_rd || mem_wr || rf_inc || rf_dec || rf_wr
                    || pc_load || pc_add || done || err));                 // R9
    AST_FAULT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !(done || rf_inc || rf_dec || rf_wr || pc_load || pc_add)); // R10
    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(mem_err && (mem_rd || mem_wr)));                     // R10
    AST_FAULT_END: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !busy);                                                    // R10
    AST_POP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr |-> $past(mem_rd));                                          // R3

endmodule

bind stack_seq stack_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_err  (mem_err),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_word (mem_word),
    .rf_inc   (rf_inc),
    .rf_dec   (rf_dec),
    .rf_wr    (rf_wr),
    .pc_load  (pc_load),
    .pc_add   (pc_add),
    .busy     (busy),
    .done     (done),
    .err      (err)
);

// File: tb/stack_seq_tb.sv
// Bench: directed corner cases plus seeded random sequences, every
// output compared each cycle against a step list derived from R2..R6.
module stack_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [2:0]  sp_sel = '0;
    logic [2:0]  reg_sel = '0;
    logic [15:0] sp_val = '0;
    logic [15:0] src_val = '0;
    logic [15:0] pc_next = '0;
    logic [15:0] imm_word = '0;
    logic [15:0] mem_rdata = '0;
    logic        mem_err = 1'b0;
    logic [15:0] mem_addr, mem_wdata, rf_wr_data, pc_value;
    logic        mem_rd, mem_wr, mem_word, rf_inc, rf_dec, rf_wr;
    logic        pc_load, pc_add, busy, done, err;
    logic [2:0]  rf_step_sel, rf_wr_sel;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    stack_seq u_dut (.*);

    typedef struct packed {
        logic        rd, wr, word;
        logic [15:0] addr, wdata;
        logic        inc, dec;
        logic [2:0]  ssel;
        logic        rfw;
        logic [2:0]  wsel;
        logic [15:0] wdat;
        logic        pcl, pca;
        logic [15:0] pcv;
        logic        bsy, dn, er;
    } obs_t;

    localparam int PH_ACCW = 0, PH_ACCR = 1, PH_DEC = 2, PH_INC = 3,
                   PH_RFWR = 4, PH_PCIMM = 5, PH_PCADD = 6, PH_PCRD = 7;

    function automatic obs_t sample();
        obs_t o;
        o = '{mem_rd, mem_wr, mem_word, mem_addr, mem_wdata, rf_inc, rf_dec,
              rf_step_sel, rf_wr, rf_wr_sel, rf_wr_data, pc_load, pc_add,
              pc_value, busy, done, err};
        return o;
    endfunction

    task automatic check(input obs_t e, input string tag);
        obs_t a;
        a = sample();
        n_chk++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, a, e);
        end
    endtask

    // Step list per opcode, from R2..R6.
    function automatic int phase(input int o, input int k);
        case (o)
            0: return (k == 0) ? PH_ACCW : PH_DEC;
            1: return (k == 0) ? PH_INC : (k == 1) ? PH_ACCR : PH_RFWR;
            2: return (k == 0) ? PH_DEC : (k == 1) ? PH_ACCW : PH_PCIMM;
            3: return (k == 0) ? PH_DEC : (k == 1) ? PH_ACCW : PH_PCADD;
            default: return (k == 0) ? PH_ACCR : (k == 1) ? PH_PCRD : PH_INC;
        endcase
    endfunction

    function automatic obs_t expect_step(input int o, input int ph, input bit last,
        input logic [2:0] spi, input logic [2:0] ri, input logic [15:0] sp,
        input logic [15:0] src, input logic [15:0] pc, input logic [15:0] imm,
        input logic [15:0] rd);
        obs_t e;
        e = '0;
        e.bsy = 1'b1;
        e.dn  = last;
        case (ph)
            PH_ACCW: begin
                e.wr = 1'b1; e.word = 1'b1;
                e.addr  = (o == 0) ? sp : sp - 16'd2;
                e.wdata = (o == 0) ? src : pc;
            end
            PH_ACCR: begin
                e.rd = 1'b1; e.word = 1'b1;
                e.addr = (o == 1) ? sp + 16'd2 : sp;
            end
            PH_DEC:   begin e.dec = 1'b1; e.ssel = spi; end
            PH_INC:   begin e.inc = 1'b1; e.ssel = spi; end
            PH_RFWR:  begin e.rfw = 1'b1; e.wsel = ri; e.wdat = rd; end
            PH_PCIMM: begin e.pcl = 1'b1; e.pcv = imm; end
            PH_PCADD: begin e.pca = 1'b1; e.pcv = imm; end
            default:  begin e.pcl = 1'b1; e.pcv = rd; end
        endcase
        return e;
    endfunction

    function automatic string req_of(input int o);
        case (o)
            0: return "R2/R7";
            1: return "R3/R7";
            2: return "R4/R7";
            3: return "R5/R7";
            default: return "R6/R7";
        endcase
    endfunction

    task automatic run_seq(input int o, input logic [2:0] spi, input logic [2:0] ri,
        input logic [15:0] sp, input logic [15:0] src, input logic [15:0] pc,
        input logic [15:0] imm, input logic [15:0] rd, input bit fault,
        input bit spur, input string tag);
        int  nsteps;
        bit  abort_next;
        bit  fin;
        int  k;
        obs_t e;
        nsteps = (o == 0) ? 2 : 3;
        @(negedge clk);
        start = 1'b1; op = 3'(o); sp_sel = spi; reg_sel = ri;
        sp_val = sp; src_val = src; pc_next = pc; imm_word = imm;
        mem_rdata = rd; mem_err = fault;
        k = 0; abort_next = 1'b0; fin = 1'b0;
        while (!fin) begin
            @(negedge clk);
            if (abort_next) begin
                e = '0; e.bsy = 1'b1; e.er = 1'b1;
                check(e, {tag, " R10 fault step"});
                fin = 1'b1;
            end else begin
                int ph;
                ph = phase(o, k);
                e = expect_step(o, ph, k == nsteps - 1, spi, ri, sp, src, pc, imm, rd);
                check(e, {tag, " ", req_of(o), " R8"});
                if (fault && (ph == PH_ACCW || ph == PH_ACCR)) abort_next = 1'b1;
                else if (k == nsteps - 1) fin = 1'b1;
            end
            // Scramble operands after accept (R7); spurious start at first step (R9).
            start = (k == 0) && spur;
            op = 3'($urandom_range(0, 4));
            sp_sel = 3'($urandom); reg_sel = 3'($urandom);
            sp_val = 16'($urandom); src_val = 16'($urandom);
            pc_next = 16'($urandom); imm_word = 16'($urandom);
            k++;
        end
        start = 1'b0; mem_err = 1'b0;
        @(negedge clk);
        check('0, {tag, " R9 idle after sequence"});
    endtask

    task automatic run_bad_op(input logic [2:0] code);
        @(negedge clk);
        start = 1'b1; op = code; sp_val = 16'h1234; src_val = 16'h5678;
        @(negedge clk);
        start = 1'b0;
        check('0, "R11 undefined opcode ignored");
        @(negedge clk);
        check('0, "R11 undefined opcode still idle");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check('0, "R1 outputs during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check('0, "R1 idle after reset");

        // Directed corner cases.
        run_seq(0, 3'd7, 3'd0, 16'h1000, 16'hBEEF, 16'h0, 16'h0, 16'h0, 0, 0, "push r7");
        run_seq(1, 3'd7, 3'd3, 16'hFFFE, 16'h0, 16'h0, 16'h0, 16'hA5A5, 0, 0, "pop wrap R12");
        run_seq(2, 3'd0, 3'd0, 16'h0000, 16'h0, 16'h0104, 16'h2000, 16'h0, 0, 1, "call-abs wrap R12");
        run_seq(3, 3'd5, 3'd0, 16'h0800, 16'h0, 16'h0310, 16'hFFF0, 16'h0, 0, 1, "call-rel");
        run_seq(4, 3'd7, 3'd0, 16'h07FE, 16'h0, 16'h0, 16'h0, 16'h0104, 0, 0, "return");
        run_seq(0, 3'd2, 3'd0, 16'h0100, 16'h1111, 16'h0, 16'h0, 16'h0, 1, 0, "push fault R10");
        run_seq(1, 3'd1, 3'd6, 16'h0100, 16'h0, 16'h0, 16'h0, 16'h2222, 1, 0, "pop fault R10");
        run_seq(4, 3'd7, 3'd0, 16'h0200, 16'h0, 16'h0, 16'h0, 16'h3333, 1, 1, "return fault R10");
        run_bad_op(3'd5);
        run_bad_op(3'd7);

        // Random sequences.
        for (int i = 0; i < 300; i++) begin
            int o;
            o = int'($urandom_range(0, 5));
            if (o == 5) begin
                run_bad_op(3'(5 + $urandom_range(0, 2)));
            end else begin
                run_seq(o, 3'($urandom), 3'($urandom), 16'($urandom), 16'($urandom),
                        16'($urandom), 16'($urandom), 16'($urandom),
                        ($urandom_range(0, 7) == 0), $urandom_range(0, 1) == 1, "random");
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule